// File: doc/BRIEF.md
# Bytecode Jump Instruction Executor

This block carries out a single jump instruction of a byte-oriented virtual instruction set. When started with the address of the instruction, it reads the instruction one byte at a time over a byte-fetch port. It then reads one general register through a register-file read port. For the indirect 32-bit forms it also makes one 32-bit data-memory read. At the end it reports the next instruction pointer together with either a taken indication, an instruction-encoding exception or an alignment exception.

The instruction is 2, 6 or 10 bytes long. The first byte says whether 32-bit immediate/index data follows and whether the instruction is the 64-bit form. The second byte holds the condition, the addressing mode, the operand mode and the register number. A relative jump adds its operand to the address of the following instruction. A jump that is not taken falls through to that address. All results appear together in a one-cycle pulse on `done_o`.

Top module: `bcj_jump_exec`

## Requirements
- R1: Instruction length is 2 bytes when byte 0 bit 7 is clear and bit 6 is clear. It is 6 bytes when bit 7 is set and bit 6 is clear, and 10 bytes when bit 6 is set. A jump that is not taken reports `next_ip_o` = start address + length.
- R2: In the 32-bit direct form (byte 1 bit 3 clear), the operand is the register value plus the sign-extended little-endian 32-bit immediate in bytes 2..5. The immediate is taken as zero when absent. Register number 0 (byte 1 bits 2:0) supplies zero whatever the register port returns.
- R3: In the 32-bit indirect form (byte 1 bit 3 set), one memory read is made at register value + sign-extended index (index zero when absent). The returned 32-bit word, sign-extended, becomes the operand. The read address is held until `mem_valid_i`.
- R4: An absolute jump (byte 1 bit 4 clear) targets the operand. A relative jump (bit 4 set) targets start address + length + operand.
- R5: The 64-bit form takes its operand from the little-endian 64-bit immediate in bytes 2..9. It ignores the register and direct/indirect fields and makes no memory read.
- R6: With byte 1 bit 7 clear the jump is always taken and bit 6 is ignored. With bit 7 set the jump is taken only when `carry_i` equals byte 1 bit 6.
- R7: The 64-bit form with byte 0 bit 7 clear, or any instruction with byte 1 bit 5 set, raises `enc_fault_o`. In that case `taken_o` is low and `next_ip_o` equals the start address.
- R8: A taken jump whose target is odd raises `align_fault_o` instead of jumping. `taken_o` is then low and `next_ip_o` equals the start address.
- R9: `done_o` is a single-cycle pulse carrying at most one of taken, encoding fault and alignment fault. Reset clears all outputs and abandons an instruction in progress.
- R10: Byte k is requested at start address + k. A request and its address are held until `fetch_valid_i`, so any number of stall cycles is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an instruction (accepted when idle) |
| ip_i | input | XLEN | Address of the instruction's first byte |
| fetch_req_o | output | 1 | Byte-fetch request |
| fetch_addr_o | output | XLEN | Byte address requested |
| fetch_valid_i | input | 1 | Fetched byte present |
| fetch_data_i | input | 8 | Fetched byte |
| reg_sel_o | output | 3 | Register number for the read port |
| reg_val_i | input | XLEN | Register value |
| carry_i | input | 1 | Carry flag |
| mem_req_o | output | 1 | Data-memory read request |
| mem_addr_o | output | XLEN | Data-memory read address |
| mem_valid_i | input | 1 | Read data present |
| mem_data_i | input | 32 | Read data word |
| done_o | output | 1 | Result pulse |
| next_ip_o | output | XLEN | Next instruction pointer |
| taken_o | output | 1 | Jump taken |
| enc_fault_o | output | 1 | Instruction-encoding exception |
| align_fault_o | output | 1 | Alignment exception |

## Verification
The hold properties on the fetch and memory ports take for granted that a responder raises its valid only while the matching request is high. The bench responders derive valid from the request itself, optionally gated by a toggling stall pattern. The result checks rely on `reg_val_i` following `reg_sel_o` and on `carry_i` being steady for the whole instruction. The bench computes the register value combinationally from `reg_sel_o` and sets the carry before each start pulse.

// File: rtl/bcj_pkg.sv
`timescale 1ns/1ps
// bcj_pkg: shared types and constants of the jump executor.
// Assumes the byte layout given in the brief.
package bcj_pkg;

    localparam int unsigned LEN_BARE = 2;   // no data bytes
    localparam int unsigned LEN_DATA = 6;   // 32-bit data
    localparam int unsigned LEN_WIDE = 10;  // 64-bit data

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BASE,
        ST_MEM,
        ST_EXEC
    } bcj_state_e;

    typedef struct packed {
        logic       wide;      // 64-bit form
        logic       has_data;  // data bytes follow
        logic       cond;      // conditional jump
        logic       on_set;    // condition: carry set
        logic       rel;       // relative target
        logic       indirect;  // operand read from memory
        logic [2:0] rsel;      // register number
    } bcj_fields_t;

endpackage

// File: rtl/bcj_decode.sv
`timescale 1ns/1ps
// bcj_decode: splits the two header bytes into fields, instruction length
// and the encoding-error flag. Purely combinational.
// Assumes hdr_i = byte0[7:6], b1_i = full byte 1.
module bcj_decode
    import bcj_pkg::*;
(
    input  logic [1:0]  hdr_i,
    input  logic [7:0]  b1_i,
    output bcj_fields_t fld_o,
    output logic [3:0]  len_o,
    output logic        enc_err_o
);

    // Field extraction and length selection
    always_comb begin
        fld_o.has_data = hdr_i[1];
        fld_o.wide     = hdr_i[0];
        fld_o.cond     = b1_i[7];
        fld_o.on_set   = b1_i[6];
        fld_o.rel      = b1_i[4];
        fld_o.indirect = b1_i[3];
        fld_o.rsel     = b1_i[2:0];
        if (hdr_i[0])
            len_o = 4'(LEN_WIDE);
        else if (hdr_i[1])
            len_o = 4'(LEN_DATA);
        else
            len_o = 4'(LEN_BARE);
        enc_err_o = (hdr_i[0] & ~hdr_i[1]) | b1_i[5];
    end

endmodule

// File: rtl/bcj_target.sv
`timescale 1ns/1ps
// bcj_target: fall-through address, jump target and condition outcome.
// Assumes the operand is already resolved (register, immediate or memory).
module bcj_target #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] ip_i,
    input  logic [3:0]      len_i,
    input  logic            rel_i,
    input  logic [XLEN-1:0] opnd_i,
    input  logic            cond_i,
    input  logic            on_set_i,
    input  logic            carry_i,
    output logic [XLEN-1:0] fall_o,
    output logic [XLEN-1:0] target_o,
    output logic            take_o
);

    // Address arithmetic and condition test
    always_comb begin
        fall_o   = ip_i + XLEN'(len_i);
        target_o = rel_i ? (fall_o + opnd_i) : opnd_i;
        take_o   = ~cond_i | (carry_i == on_set_i);
    end

endmodule

// File: rtl/bcj_jump_exec.sv
`timescale 1ns/1ps
// bcj_jump_exec: executes one variable-length jump instruction.
// Sequence: fetch bytes one per accepted beat, resolve the base operand,
// optionally read memory, then evaluate and emit a one-cycle result.
// Assumes reg_val_i follows reg_sel_o combinationally and carry_i is
// steady while an instruction runs; responders answer only on request.
module bcj_jump_exec
    import bcj_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] ip_i,
    output logic            fetch_req_o,
    output logic [XLEN-1:0] fetch_addr_o,
    input  logic            fetch_valid_i,
    input  logic [7:0]      fetch_data_i,
    output logic [2:0]      reg_sel_o,
    input  logic [XLEN-1:0] reg_val_i,
    input  logic            carry_i,
    output logic            mem_req_o,
    output logic [XLEN-1:0] mem_addr_o,
    input  logic            mem_valid_i,
    input  logic [IMM_W-1:0] mem_data_i,
    output logic            done_o,
    output logic [XLEN-1:0] next_ip_o,
    output logic            taken_o,
    output logic            enc_fault_o,
    output logic            align_fault_o
);

    localparam int NBYTES = XLEN / 8;
    localparam int EXT_W  = XLEN - IMM_W;

    bcj_state_e      state_q;
    logic [XLEN-1:0] ip_q;
    logic [3:0]      idx_q;
    logic [1:0]      hdr0_q;
    logic [7:0]      hdr1_q;
    logic [XLEN-1:0] imm_q;
    logic [XLEN-1:0] opnd_q;

    logic [7:0]      b1_now;
    bcj_fields_t     fld;
    logic [3:0]      len;
    logic            enc_err;
    logic [XLEN-1:0] fall_ip, target;
    logic            take;
    logic [XLEN-1:0] base, imm_ext;

    // Byte 1 is decoded straight from the port in the beat it arrives
    always_comb begin
        b1_now = (state_q == ST_FETCH && idx_q == 4'd1) ? fetch_data_i : hdr1_q;
    end

    bcj_decode u_decode (
        .hdr_i     (hdr0_q),
        .b1_i      (b1_now),
        .fld_o     (fld),
        .len_o     (len),
        .enc_err_o (enc_err)
    );

    bcj_target #(.XLEN(XLEN)) u_target (
        .ip_i     (ip_q),
        .len_i    (len),
        .rel_i    (fld.rel),
        .opnd_i   (opnd_q),
        .cond_i   (fld.cond),
        .on_set_i (fld.on_set),
        .carry_i  (carry_i),
        .fall_o   (fall_ip),
        .target_o (target),
        .take_o   (take)
    );

    // Base register (R0 reads zero) and sign-extended 32-bit data
    always_comb begin
        base    = (fld.rsel == 3'd0) ? '0 : reg_val_i;
        imm_ext = fld.has_data ? {{EXT_W{imm_q[IMM_W-1]}}, imm_q[IMM_W-1:0]} : '0;
    end

    // Port drives derived from the sequencer state
    always_comb begin
        fetch_req_o  = (state_q == ST_FETCH);
        fetch_addr_o = ip_q + XLEN'(idx_q);
        reg_sel_o    = fld.rsel;
        mem_req_o    = (state_q == ST_MEM);
        mem_addr_o   = opnd_q;
    end

    // Instruction sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            ip_q          <= '0;
            idx_q         <= '0;
            hdr0_q        <= '0;
            hdr1_q        <= '0;
            imm_q         <= '0;
            opnd_q        <= '0;
            done_o        <= 1'b0;
            next_ip_o     <= '0;
            taken_o       <= 1'b0;
            enc_fault_o   <= 1'b0;
            align_fault_o <= 1'b0;
        end else begin
            done_o        <= 1'b0;
            taken_o       <= 1'b0;
            enc_fault_o   <= 1'b0;
            align_fault_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ip_q    <= ip_i;
                        idx_q   <= '0;
                        imm_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_valid_i) begin
                        if (idx_q == 4'd0) begin
                            hdr0_q <= fetch_data_i[7:6];
                            idx_q  <= 4'd1;
                        end else begin
                            if (idx_q == 4'd1)
                                hdr1_q <= fetch_data_i;
                            for (int k = 0; k < NBYTES; k++) begin
                                if (idx_q == 4'(k + 2))
                                    imm_q[k*8 +: 8] <= fetch_data_i;
                            end
                            if (idx_q == 4'd1 && enc_err) begin
                                done_o      <= 1'b1;
                                enc_fault_o <= 1'b1;
                                next_ip_o   <= ip_q;
                                state_q     <= ST_IDLE;
                            end else if (idx_q == len - 4'd1) begin
                                state_q <= ST_BASE;
                            end else begin
                                idx_q <= idx_q + 4'd1;
                            end
                        end
                    end
                end
                ST_BASE: begin
                    opnd_q  <= fld.wide ? imm_q : (base + imm_ext);
                    state_q <= (!fld.wide && fld.indirect) ? ST_MEM : ST_EXEC;
                end
                ST_MEM: begin
                    if (mem_valid_i) begin
                        opnd_q  <= {{EXT_W{mem_data_i[IMM_W-1]}}, mem_data_i};
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    done_o <= 1'b1;
                    if (take && target[0]) begin
                        align_fault_o <= 1'b1;
                        next_ip_o     <= ip_q;
                    end else if (take) begin
                        taken_o   <= 1'b1;
                        next_ip_o <= target;
                    end else begin
                        next_ip_o <= fall_ip;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // At most one outcome flag per result
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({taken_o, enc_fault_o, align_fault_o}) <= 1));

    // A taken jump never lands on an odd address
    assert_even_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && taken_o) |-> !next_ip_o[0]);

    // Fetch request and address held through stalls
    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_valid_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

    // Memory request and address held through stalls
    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // Only the 32-bit indirect form reaches the memory port
    assert_no_wide_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (!hdr0_q[0] && hdr1_q[3]));

endmodule

// File: tb/test_bcj_jump_exec.sv
`timescale 1ns/1ps
// test_bcj_jump_exec: vector table walk plus directed reset and stall tests.
module test_bcj_jump_exec;

    localparam int XLEN = 64;
    localparam logic [XLEN-1:0] IP0 = 64'h400;

    typedef struct packed {
        logic [79:0]     code;    // byte 0 in bits 7:0
        logic            carry;
        logic [XLEN-1:0] exp_ip;
        logic            exp_t;
        logic            exp_e;
        logic            exp_a;
        logic [7:0]      req;
    } vec_t;

    // Registers: r0=0xDEAD (must read as zero), r1=0x100, r2=0x2000, r3=3.
    // Memory: 0x120 -> 0x40, 0x2000 -> 0xFFFFFFF0, elsewhere 0x11.
    localparam vec_t VECS [0:20] = '{
        '{80'h0000_0000_0000_0020_0181, 1'b0, 64'h120,          1'b1, 1'b0, 1'b0, 8'd2}, // R2 abs direct r1+0x20
        '{80'h0000_0000_FFFF_FFF0_1281, 1'b0, 64'h23F6,         1'b1, 1'b0, 1'b0, 8'd4}, // R4 rel, r2-16
        '{80'h0000_0000_0000_0000_0001, 1'b0, 64'h0,            1'b1, 1'b0, 1'b0, 8'd2}, // R2 r0 reads zero
        '{80'h0000_0000_0000_0000_1001, 1'b0, 64'h402,          1'b1, 1'b0, 1'b0, 8'd4}, // R4 rel of zero
        '{80'h0000_0000_0000_0020_0981, 1'b0, 64'h40,           1'b1, 1'b0, 1'b0, 8'd3}, // R3 indirect abs
        '{80'h0000_0000_0000_0000_1A01, 1'b0, 64'h3F2,          1'b1, 1'b0, 1'b0, 8'd3}, // R3 indirect rel, negative
        '{80'h0000_0000_0000_0020_C181, 1'b0, 64'h406,          1'b0, 1'b0, 1'b0, 8'd6}, // R6 cs, carry clear
        '{80'h0000_0000_0000_0020_C181, 1'b1, 64'h120,          1'b1, 1'b0, 1'b0, 8'd6}, // R6 cs, carry set
        '{80'h0000_0000_0000_0020_8181, 1'b0, 64'h120,          1'b1, 1'b0, 1'b0, 8'd6}, // R6 cc, carry clear
        '{80'h0000_0000_0000_0020_8181, 1'b1, 64'h406,          1'b0, 1'b0, 1'b0, 8'd6}, // R6 cc, carry set
        '{80'h0000_0000_0000_0020_4181, 1'b0, 64'h120,          1'b1, 1'b0, 1'b0, 8'd6}, // R6 uncond ignores bit 6
        '{80'h0000_1234_5678_9ABC_0BC1, 1'b0, 64'h1234_5678_9ABC, 1'b1, 1'b0, 1'b0, 8'd5}, // R5 wide ignores r3/indirect
        '{80'h0000_0000_0000_0100_10C1, 1'b0, 64'h50A,          1'b1, 1'b0, 1'b0, 8'd5}, // R5 wide relative
        '{80'h0000_0000_0000_0000_0041, 1'b0, IP0,              1'b0, 1'b1, 1'b0, 8'd7}, // R7 wide without data
        '{80'h0000_0000_0000_0020_2181, 1'b0, IP0,              1'b0, 1'b1, 1'b0, 8'd7}, // R7 reserved bit set
        '{80'h0000_0000_0000_0000_0301, 1'b0, IP0,              1'b0, 1'b0, 1'b1, 8'd8}, // R8 odd register target
        '{80'h0000_0000_0000_0030_0981, 1'b0, IP0,              1'b0, 1'b0, 1'b1, 8'd8}, // R8 odd memory target
        '{80'h0000_0000_0000_0000_C301, 1'b0, 64'h402,          1'b0, 1'b0, 1'b0, 8'd8}, // R8 odd but not taken
        '{80'h0000_0000_0000_0001_10C1, 1'b0, IP0,              1'b0, 1'b0, 1'b1, 8'd8}, // R8 wide rel odd
        '{80'h0000_0000_0000_0000_8001, 1'b1, 64'h402,          1'b0, 1'b0, 1'b0, 8'd1}, // R1 two-byte fall through
        '{80'h0000_0000_0000_0200_C0C1, 1'b0, 64'h40A,          1'b0, 1'b0, 1'b0, 8'd1}  // R1 ten-byte fall through
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [XLEN-1:0] ip_in = '0;
    logic            fetch_req, fetch_valid;
    logic [XLEN-1:0] fetch_addr;
    logic [7:0]      fetch_data;
    logic [2:0]      reg_sel;
    logic [XLEN-1:0] reg_val;
    logic            carry = 1'b0;
    logic            mem_req, mem_valid;
    logic [XLEN-1:0] mem_addr;
    logic [31:0]     mem_data;
    logic            done, taken, enc_f, align_f;
    logic [XLEN-1:0] next_ip;

    logic [79:0]     code_cur = '0;
    logic            stall_en = 1'b0;
    logic            tick = 1'b0;
    int              n_vec = 0;
    int              n_bad = 0;

    always #4 clk = ~clk;

    // Stall pattern source for the responders
    always_ff @(posedge clk) tick <= ~tick;

    function automatic logic [7:0] code_byte(input logic [XLEN-1:0] a);
        logic [XLEN-1:0] ofs;
        ofs = a - IP0;
        if (ofs < 10) return code_cur[ofs[3:0]*8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [XLEN-1:0] reg_of(input logic [2:0] s);
        case (s)
            3'd0: return 64'hDEAD;
            3'd1: return 64'h100;
            3'd2: return 64'h2000;
            3'd3: return 64'h3;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [31:0] mem_of(input logic [XLEN-1:0] a);
        case (a)
            64'h120:  return 32'h0000_0040;
            64'h2000: return 32'hFFFF_FFF0;
            default:  return 32'h0000_0011;
        endcase
    endfunction

    assign fetch_valid = fetch_req & (~stall_en | tick);
    assign fetch_data  = code_byte(fetch_addr);
    assign reg_val     = reg_of(reg_sel);
    assign mem_valid   = mem_req & (~stall_en | tick);
    assign mem_data    = mem_of(mem_addr);

    bcj_jump_exec #(.XLEN(XLEN)) i_bcj_jump_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .ip_i          (ip_in),
        .fetch_req_o   (fetch_req),
        .fetch_addr_o  (fetch_addr),
        .fetch_valid_i (fetch_valid),
        .fetch_data_i  (fetch_data),
        .reg_sel_o     (reg_sel),
        .reg_val_i     (reg_val),
        .carry_i       (carry),
        .mem_req_o     (mem_req),
        .mem_addr_o    (mem_addr),
        .mem_valid_i   (mem_valid),
        .mem_data_i    (mem_data),
        .done_o        (done),
        .next_ip_o     (next_ip),
        .taken_o       (taken),
        .enc_fault_o   (enc_f),
        .align_fault_o (align_f)
    );

    task automatic run_vec(input vec_t v, input int id);
        logic got;
        code_cur = v.code;
        carry    = v.carry;
        ip_in    = IP0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 80 && !got; c++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        n_vec++;
        if (!got || next_ip !== v.exp_ip || taken !== v.exp_t ||
            enc_f !== v.exp_e || align_f !== v.exp_a) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: got done=%b ip=%h t=%b e=%b a=%b, expected ip=%h t=%b e=%b a=%b",
                     v.req, id, got, next_ip, taken, enc_f, align_f,
                     v.exp_ip, v.exp_t, v.exp_e, v.exp_a);
        end
        @(negedge clk);
    endtask

    // Global watchdog: a hung run is one failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state of every output
        n_vec++;
        if (done || taken || enc_f || align_f || next_ip !== '0 || fetch_req || mem_req) begin
            n_bad++;
            $display("FAIL R9 reset state: got done=%b t=%b e=%b a=%b ip=%h fr=%b mr=%b, expected all zero",
                     done, taken, enc_f, align_f, next_ip, fetch_req, mem_req);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, responders answer at once (R1..R8)
        for (int i = 0; i < 21; i++) run_vec(VECS[i], i);

        // R10 / R3: same forms with stalled fetch and memory replies
        stall_en = 1'b1;
        run_vec(VECS[4], 100);   // R3 indirect under stalls
        run_vec(VECS[11], 101);  // R10 ten-byte fetch under stalls
        run_vec(VECS[1], 102);   // R10 six-byte fetch under stalls
        stall_en = 1'b0;

        // R9: reset in mid-instruction abandons it
        code_cur = VECS[0].code;
        ip_in    = IP0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        begin
            logic seen;
            seen = 1'b0;
            for (int c = 0; c < 20; c++) begin
                if (done || fetch_req || mem_req) seen = 1'b1;
                @(negedge clk);
            end
            n_vec++;
            if (seen) begin
                n_bad++;
                $display("FAIL R9 reset abort: got activity=1, expected 0");
            end
        end
        // R9: block usable again after the abort
        run_vec(VECS[1], 103);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule